// File: doc/BRIEF.md
# FIFO Service Interrupt Controller

This block raises service interrupts for a streaming engine that moves 32-bit words through an input FIFO and an output FIFO. It watches the occupancy count of each FIFO and a core-enable bit, and derives two level-sensitive sources from them.

The input-service source asks software to refill the input FIFO. It is high while the core is enabled and fewer than four words are queued. The output-service source asks software to drain the output FIFO. It is high whenever at least one result word is waiting, whether or not the core is enabled. Neither source is sticky: each clears only through FIFO activity.

A small register port gives software a mask register, a raw status register and a masked status register. A single registered interrupt line carries the OR of the two masked sources.

Top module: `fifo_svc_irq`

## Requirements
- R1: After reset the mask register, the raw status, the masked status and `irq_o` all read 0.
- R2: Raw status bit 0 (input source) equals `core_en_i` AND (`in_level_i` < 4). It is sampled at each clock edge and readable at address 1 after that edge.
- R3: Raw status bit 1 (output source) equals (`out_level_i` != 0), independent of `core_en_i`. It is sampled at each clock edge and readable at address 1.
- R4: Address 0 is the mask register. A write stores `reg_wdata_i[1:0]`, with bit 0 masking the input source and bit 1 masking the output source, where 1 enables. A read returns the stored bits with bits 31:2 at 0.
- R5: Address 2 reads the masked status, which is the raw status AND the mask, with bits 31:2 at 0.
- R6: `irq_o` is registered. At each edge it takes the OR of (current source conditions AND the mask held before that edge). A change in occupancy or enable therefore shows after one edge, and a mask write shows after the edge that follows the write.
- R7: Writes to address 1 or address 2 have no effect on the mask or on either status register.
- R8: A read of address 3 returns 0.
- R9: With `core_en_i` low, the input source stays low even when the input FIFO is empty. An output source that is already high stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_en_i | input | 1 | Processing core enable |
| in_level_i | input | CNT_W | Input FIFO word count |
| out_level_i | input | CNT_W | Output FIFO word count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 mask, 1 raw, 2 masked) |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational from address) |
| irq_o | output | 1 | Combined service interrupt |

## Verification
A wrong source term or a bad threshold compare shows at address 1 and at `irq_o` one edge after the occupancy that exposes it. The bench therefore sweeps every combination of enable, input levels across the threshold, output levels 0 to 3 and all mask values, and checks each point after two edges. A corrupted mask register shows at once at address 0 and at address 2, and shows one edge later at `irq_o`. An off-by-one-edge error in the interrupt register is caught by a dedicated sequence that samples `irq_o` between the mask write and the following edge.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int unsigned SRC_N   = 2;
  localparam int unsigned SRC_IN  = 0;
  localparam int unsigned SRC_OUT = 1;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_RAW  = 2'd1,
    REG_MIS  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fsi_src_eval.sv
module fsi_src_eval
  import fsi_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned IN_THRESH = 4
) (
  input  logic             core_en_i,
  input  logic [CNT_W-1:0] in_level_i,
  input  logic [CNT_W-1:0] out_level_i,
  output logic [SRC_N-1:0] raw_o
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(IN_THRESH);

  logic in_low;
  logic out_any;

  assign in_low  = (in_level_i < THR);
  assign out_any = |out_level_i;

  // input side gated by enable, output side not
  always_comb begin
    raw_o          = '0;
    raw_o[SRC_IN]  = core_en_i & in_low;
    raw_o[SRC_OUT] = out_any;
  end
endmodule

// File: rtl/fsi_regs.sv
module fsi_regs
  import fsi_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SRC_N-1:0]  raw_i,
  output logic [SRC_N-1:0]  mask_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [SRC_N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (we_i && (addr_i == REG_MASK)) begin
      mask_q <= wdata_i[SRC_N-1:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_MASK: rdata_o = DATA_W'(mask_q);
      REG_RAW:  rdata_o = DATA_W'(raw_i);
      REG_MIS:  rdata_o = DATA_W'(raw_i & mask_q);
      default:  rdata_o = '0;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/fsi_irq_core.sv
module fsi_irq_core
  import fsi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] raw_next_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic [SRC_N-1:0] raw_q_o,
  output logic             irq_o
);
  logic [SRC_N-1:0] raw_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_next_i;
      irq_q <= |(raw_next_i & mask_i);
    end
  end

  assign raw_q_o = raw_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq
  import fsi_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IN_THRESH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_en_i,
  input  logic [CNT_W-1:0]  in_level_i,
  input  logic [CNT_W-1:0]  out_level_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [SRC_N-1:0] raw_next;
  logic [SRC_N-1:0] raw_q;
  logic [SRC_N-1:0] mask_q;

  fsi_src_eval #(
    .CNT_W    (CNT_W),
    .IN_THRESH(IN_THRESH)
  ) u_src (
    .core_en_i  (core_en_i),
    .in_level_i (in_level_i),
    .out_level_i(out_level_i),
    .raw_o      (raw_next)
  );

  fsi_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .raw_i  (raw_q),
    .mask_o (mask_q),
    .rdata_o(reg_rdata_o)
  );

  fsi_irq_core u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_next_i(raw_next),
    .mask_i    (mask_q),
    .raw_q_o   (raw_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/fifo_svc_irq_chk.sv
module fifo_svc_irq_chk #(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IN_THRESH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_en_i,
  input logic [CNT_W-1:0]  in_level_i,
  input logic [CNT_W-1:0]  out_level_i,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              irq_o,
  input logic [1:0]        raw_q,
  input logic [1:0]        mask_q
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(IN_THRESH);

  // R2
  in_src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_en_i && (in_level_i < THR)) |=> raw_q[0]);

  // R2 R9
  in_src_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_en_i || (in_level_i >= THR)) |=> !raw_q[0]);

  // R3
  out_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_level_i != '0) |=> raw_q[1]);

  // R3
  out_src_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_level_i == '0) |=> !raw_q[1]);

  // R6
  irq_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_q & $past(mask_q)) != 2'b00));

  // R7
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i || (reg_addr_i != 2'd0)) |=> $stable(mask_q));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd3) |-> (reg_rdata_o == '0));
endmodule

bind fifo_svc_irq fifo_svc_irq_chk #(
  .CNT_W    (CNT_W),
  .DATA_W   (DATA_W),
  .IN_THRESH(IN_THRESH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .core_en_i  (core_en_i),
  .in_level_i (in_level_i),
  .out_level_i(out_level_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .raw_q      (raw_q),
  .mask_q     (mask_q)
);

// File: tb/fifo_svc_irq_tb.sv
`timescale 1ns/1ps
module fifo_svc_irq_tb;
  localparam int unsigned CNT_W  = 5;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              core_en = 1'b0;
  logic [CNT_W-1:0]  in_level = '0;
  logic [CNT_W-1:0]  out_level = '0;
  logic              we = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_svc_irq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .core_en_i(core_en),
    .in_level_i(in_level), .out_level_i(out_level),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [1:0]  raw_e;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 mask", v, 0);
    rd(2'd1, v); chk("R1 raw", v, 0);
    rd(2'd2, v); chk("R1 mis", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rst_ni = 1'b1;

    // sweep: R2 R3 R4 R5 R6 R9
    for (int en = 0; en < 2; en++)
      for (int il = 0; il < 8; il++)
        for (int ol = 0; ol < 4; ol++)
          for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            we = 1'b1; addr = 2'd0; wdata = {30'h3fff_ffff, m[1:0]};
            core_en = en[0]; in_level = CNT_W'(il); out_level = CNT_W'(ol);
            @(negedge clk);
            we = 1'b0;
            @(negedge clk);
            raw_e = {(ol != 0), (en == 1) && (il < 4)};
            rd(2'd1, v); chk(en == 0 ? "R9 raw" : "R2/R3 raw", v, {30'd0, raw_e});
            rd(2'd2, v); chk("R5 mis", v, {30'd0, raw_e & m[1:0]});
            rd(2'd0, v); chk("R4 mask", v, {30'd0, m[1:0]});
            chk("R6 irq", {31'd0, irq}, {31'd0, |(raw_e & m[1:0])});
          end

    // R6 timing: mask write then irq one edge later
    wr(2'd0, 32'd0);
    @(negedge clk);
    core_en = 1'b1; in_level = '0; out_level = '0;
    @(negedge clk);
    we = 1'b1; addr = 2'd0; wdata = 32'd1;
    @(posedge clk); #0.5;
    we = 1'b0;
    chk("R6 irq after mask edge", {31'd0, irq}, 0);
    @(posedge clk); #0.5;
    chk("R6 irq next edge", {31'd0, irq}, 1);
    @(negedge clk);
    in_level = 5'd4;
    #0.5;
    chk("R6 irq before edge", {31'd0, irq}, 1);
    @(posedge clk); #0.5;
    chk("R6 irq clears", {31'd0, irq}, 0);

    // R9 disable: output stays, input dropped
    wr(2'd0, 32'd3);
    @(negedge clk);
    core_en = 1'b0; in_level = '0; out_level = 5'd3;
    @(negedge clk);
    @(negedge clk);
    rd(2'd1, v); chk("R9 disabled raw", v, 32'd2);
    chk("R9 irq from output", {31'd0, irq}, 1);
    out_level = '0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 irq drained", {31'd0, irq}, 0);

    // R7 writes to status have no effect
    core_en = 1'b1;
    wr(2'd0, 32'd1);
    wr(2'd1, 32'hffff_ffff);
    wr(2'd2, 32'hffff_ffff);
    @(negedge clk);
    rd(2'd0, v); chk("R7 mask kept", v, 32'd1);
    rd(2'd1, v); chk("R7 raw kept", v, 32'd1);
    rd(2'd2, v); chk("R7 mis kept", v, 32'd1);

    // R4 upper bits, R8 unmapped
    wr(2'd0, 32'hffff_fffe);
    rd(2'd0, v); chk("R4 upper zero", v, 32'd2);
    rd(2'd3, v); chk("R8 unmapped", v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule